// File: doc/BRIEF.md
# FIFO Flag Offset Programming Unit

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag comparators use, and it provides the ways of setting them. When master reset is applied, the level of the load input picks a default offset, written into both registers, and it also fixes how software programs the offsets afterwards. One choice is a bit-serial stream on a single pin. The other is whole words taken from the FIFO's data input bus.

Programming takes place only while the load input is high, so offset writes never reach FIFO storage. The same load input, together with the read enable, returns the offsets one after the other on the data output bus. Read-back works in either programming method. Partial reset puts the write and read sequencing back at its start. It keeps the offsets and the chosen method, so a FIFO can be restarted without programming its flags again.

Top module: `ofs_prog_unit`

## Requirements
- R1: A master reset cycle with `ld_i` low loads DEF_LO (127) into both offsets and selects word-wide programming.
- R2: A master reset cycle with `ld_i` high loads DEF_HI (1023) into both offsets and selects bit-serial programming.
- R3: In bit-serial mode, each `wclk` edge with `sen_i` and `ld_i` high writes `si_i` into the next offset bit. Bits go least significant first, almost-empty bits 0..OFS_W-1 come before almost-full bits 0..OFS_W-1, and the position returns to almost-empty bit 0 after 2*OFS_W bits. The new value appears on the offset outputs after that edge.
- R4: In word-wide mode, each `wclk` edge with `wen_i` and `ld_i` high writes `din_i[OFS_W-1:0]` into one offset. The target alternates, almost-empty first and then almost-full.
- R5: Each `rclk` edge with `ren_i` and `ld_i` high registers one offset onto `dout_o[OFS_W-1:0]`, with the upper bits zero. The source alternates, almost-empty first. On any other edge `dout_o` holds its value.
- R6: `wen_i` has no effect in bit-serial mode, and `sen_i` has no effect in word-wide mode.
- R7: While `ld_i` is low, the offsets do not change and `dout_o` holds.
- R8: A partial reset cycle keeps the offsets, the programming method and `dout_o`. It returns the write selector, the read selector and the serial bit position to their start. Load requests made in that same cycle are ignored.
- R9: Master reset clears `dout_o` to zero and returns both selectors and the serial bit position to their start.
- R10: When a read and a write fall on the same clock edge, the read returns the offset value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| prst_i | input | 1 | Partial reset, synchronous, active high |
| ld_i | input | 1 | Offset access select; sampled at master reset as the mode and default choice |
| sen_i | input | 1 | Serial bit strobe |
| wen_i | input | 1 | Word write strobe |
| ren_i | input | 1 | Word read strobe |
| si_i | input | 1 | Serial data bit |
| din_i | input | DATA_W | Data input bus |
| dout_o | output | DATA_W | Data output bus carrying read-back offsets |
| ae_ofs_o | output | OFS_W | Almost-empty offset to the flag logic |
| af_ofs_o | output | OFS_W | Almost-full offset to the flag logic |

## Verification
The read-back of an offset and a write to that same offset can fall on the same edge. Directed cycles raise `ren_i`, `wen_i` and `ld_i` together while both selectors point at almost-empty. The bench expects `dout_o` to carry the pre-edge value and the offset output to carry the new word afterwards. In the random phases, reads and writes overlap freely in both modes and are judged against a cycle model in the bench. Partial reset is also mixed in alongside pending load requests.

// File: rtl/ofsprog_pkg.sv
package ofsprog_pkg;
   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;

   function automatic ofs_sel_e sel_next(input ofs_sel_e s);
      return (s == SEL_AE) ? SEL_AF : SEL_AE;
   endfunction
endpackage

// File: rtl/ofsprog_wr.sv
module ofsprog_wr
   import ofsprog_pkg::*;
#(
   parameter int OFS_W  = 16,
   parameter int DATA_W = 18,
   parameter int DEF_LO = 127,
   parameter int DEF_HI = 1023
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              ld,
   input  logic              sen,
   input  logic              wen,
   input  logic              si,
   input  logic [DATA_W-1:0] din,
   output logic [OFS_W-1:0]  ae_ofs,
   output logic [OFS_W-1:0]  af_ofs,
   output logic              serial_mode
);
   localparam int NREG  = 2;
   localparam int NBITS = NREG * OFS_W;
   localparam int CNT_W = $clog2(NBITS);
   localparam int IDX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
   localparam logic [OFS_W-1:0] LO_V = OFS_W'(DEF_LO);
   localparam logic [OFS_W-1:0] HI_V = OFS_W'(DEF_HI);

   logic             serial_q;
   ofs_sel_e         wsel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             par_we;
   logic             ser_we;
   logic [NREG-1:0][OFS_W-1:0] ofs_w;

   assign par_we = !prst && ld && wen && !serial_q;
   assign ser_we = !prst && ld && sen &&  serial_q;

   always_ff @(posedge clk) begin
      if (mrst) begin
         serial_q <= ld;
         wsel_q   <= SEL_AE;
         cnt_q    <= '0;
      end else if (prst) begin
         wsel_q   <= SEL_AE;
         cnt_q    <= '0;
      end else begin
         if (par_we) wsel_q <= sel_next(wsel_q);
         if (ser_we) cnt_q  <= (int'(cnt_q) == NBITS - 1) ? '0 : cnt_q + 1'b1;
      end
   end

   for (genvar j = 0; j < NREG; j++) begin : g_reg
      localparam int BASE = j * OFS_W;
      logic [OFS_W-1:0] r_q;
      logic             bit_hit;
      logic [IDX_W-1:0] bit_idx;

      assign bit_hit = ser_we && (int'(cnt_q) >= BASE) && (int'(cnt_q) < BASE + OFS_W);
      assign bit_idx = IDX_W'(int'(cnt_q) - BASE);

      always_ff @(posedge clk) begin
         if (mrst)
            r_q <= ld ? HI_V : LO_V;
         else if (par_we && (int'(wsel_q) == j))
            r_q <= din[OFS_W-1:0];
         else if (bit_hit)
            r_q[bit_idx] <= si;
      end

      assign ofs_w[j] = r_q;
   end

   assign ae_ofs      = ofs_w[0];
   assign af_ofs      = ofs_w[1];
   assign serial_mode = serial_q;
endmodule

// File: rtl/ofsprog_rd.sv
module ofsprog_rd
   import ofsprog_pkg::*;
#(
   parameter int OFS_W  = 16,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              ld,
   input  logic              ren,
   input  logic [OFS_W-1:0]  ae_ofs,
   input  logic [OFS_W-1:0]  af_ofs,
   output logic [DATA_W-1:0] dout
);
   localparam int PAD_W = DATA_W - OFS_W;

   ofs_sel_e          rsel_q;
   logic [OFS_W-1:0]  pick;
   logic [DATA_W-1:0] word;

   assign pick = (rsel_q == SEL_AF) ? af_ofs : ae_ofs;

   if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, pick};
   end else begin : g_nopad
      assign word = pick;
   end

   always_ff @(posedge clk) begin
      if (mrst) begin
         rsel_q <= SEL_AE;
         dout   <= '0;
      end else if (prst) begin
         rsel_q <= SEL_AE;
      end else if (ren && ld) begin
         rsel_q <= sel_next(rsel_q);
         dout   <= word;
      end
   end
endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit #(
   parameter int OFS_W  = 16,
   parameter int DATA_W = 18,
   parameter int DEF_LO = 127,
   parameter int DEF_HI = 1023
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst_i,
   input  logic              prst_i,
   input  logic              ld_i,
   input  logic              sen_i,
   input  logic              wen_i,
   input  logic              ren_i,
   input  logic              si_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic [OFS_W-1:0]  ae_ofs_o,
   output logic [OFS_W-1:0]  af_ofs_o
);
   if (OFS_W < 2 || OFS_W > DATA_W) begin : g_bad_width
      $error("ofs_prog_unit: OFS_W must be in 2..DATA_W");
   end
   if (DEF_LO < 0 || DEF_HI < 0 || DEF_LO >= (1 << OFS_W) || DEF_HI >= (1 << OFS_W)) begin : g_bad_def
      $error("ofs_prog_unit: default offsets must fit in OFS_W bits");
   end

   logic serial_mode;

   ofsprog_wr #(
      .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
   ) wr_i (
      .clk(wclk), .mrst(mrst_i), .prst(prst_i), .ld(ld_i),
      .sen(sen_i), .wen(wen_i), .si(si_i), .din(din_i),
      .ae_ofs(ae_ofs_o), .af_ofs(af_ofs_o), .serial_mode(serial_mode)
   );

   ofsprog_rd #(
      .OFS_W(OFS_W), .DATA_W(DATA_W)
   ) rd_i (
      .clk(rclk), .mrst(mrst_i), .prst(prst_i), .ld(ld_i), .ren(ren_i),
      .ae_ofs(ae_ofs_o), .af_ofs(af_ofs_o), .dout(dout_o)
   );
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
   parameter int OFS_W  = 16,
   parameter int DATA_W = 18,
   parameter int DEF_LO = 127,
   parameter int DEF_HI = 1023
) (
   input logic              wclk,
   input logic              rclk,
   input logic              mrst_i,
   input logic              prst_i,
   input logic              ld_i,
   input logic              sen_i,
   input logic              wen_i,
   input logic              ren_i,
   input logic [DATA_W-1:0] dout_o,
   input logic [OFS_W-1:0]  ae_ofs_o,
   input logic [OFS_W-1:0]  af_ofs_o,
   input logic              serial_mode
);
   logic p_mrst_q, p_ld_q;

   always_ff @(posedge wclk) begin
      p_mrst_q <= mrst_i;
      p_ld_q   <= ld_i;
   end

   always_ff @(posedge wclk) begin
      if (p_mrst_q === 1'b1 && p_ld_q === 1'b0)
         assert_default_lo_R1: assert (ae_ofs_o == OFS_W'(DEF_LO) && af_ofs_o == OFS_W'(DEF_LO) && !serial_mode);
      if (p_mrst_q === 1'b1 && p_ld_q === 1'b1)
         assert_default_hi_R2: assert (ae_ofs_o == OFS_W'(DEF_HI) && af_ofs_o == OFS_W'(DEF_HI) && serial_mode);
   end

   assert_serial_ignores_wen_R6: assert property (@(posedge wclk) disable iff (mrst_i)
      serial_mode && !(sen_i && ld_i) |=> $stable(ae_ofs_o) && $stable(af_ofs_o));

   assert_parallel_ignores_sen_R6: assert property (@(posedge wclk) disable iff (mrst_i)
      !serial_mode && !(wen_i && ld_i) |=> $stable(ae_ofs_o) && $stable(af_ofs_o));

   assert_ld_low_no_write_R7: assert property (@(posedge wclk) disable iff (mrst_i)
      !ld_i |=> $stable(ae_ofs_o) && $stable(af_ofs_o));

   assert_prst_keeps_R8: assert property (@(posedge wclk) disable iff (mrst_i)
      prst_i |=> $stable(ae_ofs_o) && $stable(af_ofs_o) && $stable(serial_mode));

   assert_dout_hold_R5: assert property (@(posedge rclk) disable iff (mrst_i)
      !(ren_i && ld_i) |=> $stable(dout_o));
endmodule

bind ofs_prog_unit ofs_prog_chk #(
   .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
) chk_i (
   .wclk(wclk), .rclk(rclk), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
   .sen_i(sen_i), .wen_i(wen_i), .ren_i(ren_i), .dout_o(dout_o),
   .ae_ofs_o(ae_ofs_o), .af_ofs_o(af_ofs_o), .serial_mode(serial_mode)
);

// File: tb/ofs_prog_unit_tb_top.sv
module ofs_prog_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OFS_W  = 16;
   localparam int DATA_W = 18;
   localparam int DEF_LO = 127;
   localparam int DEF_HI = 1023;

   logic clk = 1'b0;
   logic mrst = 1'b1, prst = 1'b0, ld = 1'b0, sen = 1'b0, wen = 1'b0, ren = 1'b0, si = 1'b0;
   logic [DATA_W-1:0] din = '0;
   logic [DATA_W-1:0] dout;
   logic [OFS_W-1:0]  ae_ofs, af_ofs;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [OFS_W-1:0]  m_ae, m_af;
   logic [DATA_W-1:0] m_dout;
   logic m_serial, m_wsel, m_rsel;
   int   m_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   ofs_prog_unit #(
      .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
   ) dut_i (
      .wclk(clk), .rclk(clk), .mrst_i(mrst), .prst_i(prst), .ld_i(ld),
      .sen_i(sen), .wen_i(wen), .ren_i(ren), .si_i(si), .din_i(din),
      .dout_o(dout), .ae_ofs_o(ae_ofs), .af_ofs_o(af_ofs)
   );

   function automatic logic [DATA_W-1:0] read_word(input logic sel,
                                                   input logic [OFS_W-1:0] a,
                                                   input logic [OFS_W-1:0] f);
      return DATA_W'(sel ? f : a);
   endfunction

   function automatic logic [OFS_W-1:0] dflt(input logic l);
      return l ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
   endfunction

   task automatic model_edge();
      if (mrst) begin
         m_serial = ld;
         m_ae = dflt(ld);
         m_af = dflt(ld);
         m_wsel = 1'b0; m_rsel = 1'b0; m_cnt = 0;
         m_dout = '0;
      end else if (prst) begin
         m_wsel = 1'b0; m_rsel = 1'b0; m_cnt = 0;
      end else begin
         if (ren && ld) begin
            m_dout = read_word(m_rsel, m_ae, m_af);
            m_rsel = ~m_rsel;
         end
         if (ld && m_serial && sen) begin
            if (m_cnt < OFS_W) m_ae[m_cnt] = si;
            else               m_af[m_cnt - OFS_W] = si;
            m_cnt = (m_cnt == 2*OFS_W - 1) ? 0 : m_cnt + 1;
         end
         if (ld && !m_serial && wen) begin
            if (m_wsel) m_af = din[OFS_W-1:0];
            else        m_ae = din[OFS_W-1:0];
            m_wsel = ~m_wsel;
         end
      end
   endtask

   task automatic check(input string tag, input string what,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input logic i_mrst, input logic i_prst,
                      input logic i_ld, input logic i_sen, input logic i_wen,
                      input logic i_ren, input logic i_si, input logic [DATA_W-1:0] i_din);
      mrst = i_mrst; prst = i_prst; ld = i_ld; sen = i_sen;
      wen = i_wen; ren = i_ren; si = i_si; din = i_din;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag, "ae_ofs", DATA_W'(ae_ofs), DATA_W'(m_ae));
      check(tag, "af_ofs", DATA_W'(af_ofs), DATA_W'(m_af));
      check(tag, "dout",   dout,            m_dout);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [OFS_W-1:0] pat;
      void'($urandom(32'd1357));
      @(negedge clk);

      // R1, R9: master reset with ld low
      cyc("R1", 1, 0, 0, 0, 0, 0, 0, '0);
      cyc("R9", 1, 0, 0, 0, 0, 0, 0, '0);
      check("R1", "ae default", DATA_W'(ae_ofs), DATA_W'(127));
      check("R9", "dout reset", dout, '0);

      // R4: word writes alternate almost-empty then almost-full
      cyc("R4", 0, 0, 1, 0, 1, 0, 0, 18'h01234);
      check("R4", "ae written", DATA_W'(ae_ofs), 18'h01234);
      cyc("R4", 0, 0, 1, 0, 1, 0, 0, 18'h30055);
      check("R4", "af written", DATA_W'(af_ofs), 18'h00055);
      // R6: serial strobe ignored in word-wide mode
      cyc("R6", 0, 0, 1, 1, 0, 0, 1, '0);
      // R7: ld low blocks writes and reads
      cyc("R7", 0, 0, 0, 0, 1, 1, 0, 18'h0beef);
      check("R7", "ae held", DATA_W'(ae_ofs), 18'h01234);

      // R5: read-back alternates
      cyc("R5", 0, 0, 1, 0, 0, 1, 0, '0);
      check("R5", "first read ae", dout, 18'h01234);
      cyc("R5", 0, 0, 1, 0, 0, 1, 0, '0);
      check("R5", "second read af", dout, 18'h00055);
      cyc("R5", 0, 0, 0, 0, 0, 0, 0, '0);

      // R10: read and write of almost-empty on the same edge
      cyc("R10", 0, 0, 1, 0, 1, 1, 0, 18'h00777);
      check("R10", "read sees old ae", dout, 18'h01234);
      check("R10", "ae updated", DATA_W'(ae_ofs), 18'h00777);

      // R8: partial reset keeps offsets, restarts selectors, ignores same-cycle load
      cyc("R8", 0, 1, 1, 0, 1, 1, 0, 18'h00abc);
      check("R8", "af kept", DATA_W'(af_ofs), 18'h00055);
      cyc("R8", 0, 0, 1, 0, 1, 1, 0, 18'h00321);
      check("R8", "write back at ae", DATA_W'(ae_ofs), 18'h00321);
      check("R8", "read back at ae", dout, 18'h00777);

      // R2: master reset with ld high -> serial, 1023
      cyc("R2", 1, 0, 1, 0, 0, 0, 0, '0);
      check("R2", "af default", DATA_W'(af_ofs), DATA_W'(1023));
      // R6: word strobe ignored in serial mode
      cyc("R6", 0, 0, 1, 0, 1, 0, 0, 18'h00001);
      check("R6", "ae unchanged", DATA_W'(ae_ofs), DATA_W'(1023));

      // R3: full serial load then wrap
      pat = 16'hA5C3;
      for (int i = 0; i < OFS_W; i++) cyc("R3", 0, 0, 1, 1, 0, 0, pat[i], '0);
      check("R3", "ae serial", DATA_W'(ae_ofs), DATA_W'(16'hA5C3));
      pat = 16'h0F1E;
      for (int i = 0; i < OFS_W; i++) cyc("R3", 0, 0, 1, 1, 0, 0, pat[i], '0);
      check("R3", "af serial", DATA_W'(af_ofs), DATA_W'(16'h0F1E));
      cyc("R3", 0, 0, 1, 1, 0, 0, 1'b0, '0);
      check("R3", "wrap to ae bit0", DATA_W'(ae_ofs), DATA_W'(16'hA5C2));

      // random phases, serial then word-wide
      for (int ph = 0; ph < 2; ph++) begin
         cyc("R9", 1, 0, (ph == 0), 0, 0, 0, 0, '0);
         for (int n = 0; n < 3000; n++) begin
            cyc(ph == 0 ? "R3" : "R4",
                ($urandom_range(0, 499) == 0),
                ($urandom_range(0, 49) == 0),
                ($urandom_range(0, 3) != 0),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                DATA_W'($urandom));
            if (m_serial !== (ph == 0) && mrst == 1'b0) begin
               // a random master reset may flip the mode; restore the phase's mode
               cyc("R9", 1, 0, (ph == 0), 0, 0, 0, 0, '0);
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule